// File: doc/BRIEF.md
# Flash Stream-Programming Controller

This block is the device-side sequencer for a fast factory programming mode of a NOR-style flash array. The host writes a two-word entry command. The block then spends a fixed number of cycles checking the programming supply and the lock state of the target block. After that it accepts a stream of data words. The address of the confirming write is kept as the start address. Writing that address again sends the word to an internal pointer that walks through the block. Writing any other address inside the block moves the pointer there.

Each accepted word gets a single program pulse. A write outside the block with all-ones data ends the program phase and starts a verify phase. The verify phase rewinds the pointer to the start address and takes the same stream again. Each verify word is compared with the array, and extra pulses are applied until the word matches or a retry limit is reached. A second out-of-block all-ones write leaves the mode.

While the mode is active, every host read returns the status byte. The cell array itself lives outside the block. The block reaches it through a combinational read port and a one-cycle pulse request that names an address and a clear-mask.

Top module: `fastprog_ctrl`

## Requirements
- R1: The mode is entered only by a write with low byte 30h followed immediately by a write with low byte D0h. Any other second write returns to idle. While the mode is active, status bit 7 is 0. Status bit 0 is 1 for exactly START_CYC cycles after the confirm write. At entry, error bits 4, 3 and 1 are cleared. Outside the mode, bit 7 is 1 and bit 0 is 0.
- R2: At the end of startup, a low supply (vpp_ok=0) sets bits 4 and 3, and a locked block sets bits 4 and 1. Either failure leaves the mode with status 98h, 92h or 9Ah (both).
- R3: While the mode is active, host_rdata is the status byte zero-extended. When idle, host_rdata is the array word at host_addr. A data word of 0070h written at the start address is programmed like any other data.
- R4: After an accepted stream write, status bit 0 is 1 for exactly PULSE_CYC cycles and then 0. Host writes made while bit 0 is 1 are ignored.
- R5: Each program-phase write issues exactly one one-cycle pulse, with pulse_mask equal to the inverted data and pulse_addr equal to the selected word.
- R6: A write at the start address selects the pointer, and the pointer then advances by one with wrap inside the block. Any other in-block address is selected directly, and the pointer then points just after it.
- R7: An out-of-block write of FFFFh during the program phase starts the verify phase with the pointer back at the start address.
- R8: Each verify word is compared with the array. On a mismatch, one extra pulse (mask = inverted verify data) is applied and the compare is repeated, until the word matches.
- R9: If a word still mismatches after MAX_XTRA extra pulses, status bit 4 is set and verify continues with the next word.
- R10: An out-of-block write of FFFFh during the verify phase leaves the mode. Status is then 80h if no error occurred.
- R11: An out-of-block write whose data is not FFFFh, in either phase, sets bits 4 and 3 and leaves the mode (status 98h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data: status in mode, array word otherwise |
| vpp_ok | input | 1 | Programming supply within range |
| blk_locked | input | 1 | Target block is locked |
| cell_addr | output | AW | Array read address |
| cell_rdata | input | DW | Array read data |
| pulse_valid | output | 1 | One-cycle program pulse request |
| pulse_addr | output | AW | Word that receives the pulse |
| pulse_mask | output | DW | Bits to clear to 0 |
| status | output | 8 | Status byte |
| mode_on | output | 1 | Programming mode active |

## Verification
A host stream write can arrive in a cycle when the pulse countdown from the previous word is still running. The bench provokes this by issuing a second in-block write on the cycle right after an accepted one. It judges the outcome by three things: the total pulse count seen on the pulse interface, the target word of the dropped write still reading FFFFh after exit, and the pointer position that later writes reveal. The second overlap is a verify compare that fails in the same cycle the retry limit is reached. The bench judges it by the exact number of extra pulses, the status byte at exit, and the word after it still verifying normally.

// File: rtl/fastprog_pkg.sv
package fastprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_START,
        ST_PROG,
        ST_PPULSE,
        ST_VWAIT,
        ST_VCHK,
        ST_VPULSE
    } fp_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'h30;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    typedef struct packed {
        logic ready;
        logic pgm_err;
        logic vpp_err;
        logic lock_err;
        logic stream_busy;
    } fp_stat_t;

    localparam fp_stat_t STAT_IDLE  = '{ready: 1'b1, pgm_err: 1'b0, vpp_err: 1'b0,
                                        lock_err: 1'b0, stream_busy: 1'b0};
    localparam fp_stat_t STAT_ENTRY = '{ready: 1'b0, pgm_err: 1'b0, vpp_err: 1'b0,
                                        lock_err: 1'b0, stream_busy: 1'b1};

    // bit 7 ready, bit 4 program error, bit 3 supply error, bit 1 lock error, bit 0 stream busy
    function automatic logic [7:0] pack_status(fp_stat_t s);
        return {s.ready, 2'b00, s.pgm_err, s.vpp_err, 1'b0, s.lock_err, s.stream_busy};
    endfunction

    function automatic logic state_in_mode(fp_state_e s);
        return !(s == ST_IDLE || s == ST_ARMED);
    endfunction

endpackage

// File: rtl/fastprog_countdown.sv
module fastprog_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fastprog_addr_track.sv
module fastprog_addr_track #(
    parameter int AW      = 8,
    parameter int BLK_LOW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          rewind,
    input  logic          advance,
    input  logic [AW-1:0] cap_addr,
    input  logic [AW-1:0] host_addr,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] target,
    output logic          in_block
);
    localparam logic [BLK_LOW-1:0] ONE_LOW = 1;

    logic [AW-1:0] start_q;
    logic [AW-1:0] ptr_q;

    assign start_addr = start_q;
    assign in_block   = (host_addr[AW-1:BLK_LOW] == start_q[AW-1:BLK_LOW]);
    assign target     = (host_addr == start_q) ? ptr_q : host_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ptr_q   <= '0;
        end else if (capture) begin
            start_q <= cap_addr;
            ptr_q   <= cap_addr;
        end else if (rewind) begin
            ptr_q   <= start_q;
        end else if (advance) begin
            ptr_q   <= {target[AW-1:BLK_LOW], target[BLK_LOW-1:0] + ONE_LOW};
        end
    end
endmodule

// File: rtl/fastprog_ctrl.sv
module fastprog_ctrl
    import fastprog_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int BLK_LOW   = 4,
    parameter int START_CYC = 8,
    parameter int PULSE_CYC = 4,
    parameter int MAX_XTRA  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          vpp_ok,
    input  logic          blk_locked,
    output logic [AW-1:0] cell_addr,
    input  logic [DW-1:0] cell_rdata,
    output logic          pulse_valid,
    output logic [AW-1:0] pulse_addr,
    output logic [DW-1:0] pulse_mask,
    output logic [7:0]    status,
    output logic          mode_on
);
    localparam int CMAX = (START_CYC > PULSE_CYC) ? START_CYC : PULSE_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int XW   = $clog2(MAX_XTRA + 1);
    localparam logic [DW-1:0] ALL_ONES   = '1;
    localparam logic [CW-1:0] START_LOAD = CW'(START_CYC - 1);
    localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYC - 1);
    localparam logic [XW-1:0] XTRA_LIM   = XW'(MAX_XTRA);

    fp_state_e     st_q, st_n;
    fp_stat_t      sr_q, sr_n;
    logic          cnt_ld, cnt_zero;
    logic [CW-1:0] cnt_val;
    logic          trk_cap, trk_rew, trk_adv, in_blk;
    logic [AW-1:0] tgt, start_addr;
    logic [AW-1:0] tgt_q, tgt_n, paddr_q, paddr_n;
    logic [DW-1:0] vdata_q, vdata_n, pmask_q, pmask_n;
    logic [XW-1:0] xtra_q, xtra_n;
    logic          pls_q, pls_n;

    fastprog_countdown #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_ld), .load_val(cnt_val), .zero(cnt_zero)
    );

    fastprog_addr_track #(.AW(AW), .BLK_LOW(BLK_LOW)) u_trk (
        .clk(clk), .rst(rst), .capture(trk_cap), .rewind(trk_rew), .advance(trk_adv),
        .cap_addr(host_addr), .host_addr(host_addr), .start_addr(start_addr),
        .target(tgt), .in_block(in_blk)
    );

    always_comb begin
        st_n    = st_q;
        sr_n    = sr_q;
        cnt_ld  = 1'b0;
        cnt_val = '0;
        trk_cap = 1'b0;
        trk_rew = 1'b0;
        trk_adv = 1'b0;
        tgt_n   = tgt_q;
        vdata_n = vdata_q;
        xtra_n  = xtra_q;
        pls_n   = 1'b0;
        paddr_n = paddr_q;
        pmask_n = pmask_q;
        case (st_q)
            ST_IDLE: if (host_we && host_wdata[7:0] == CMD_SETUP) st_n = ST_ARMED;
            ST_ARMED: if (host_we) begin
                if (host_wdata[7:0] == CMD_CONFIRM) begin
                    st_n    = ST_START;
                    sr_n    = STAT_ENTRY;
                    trk_cap = 1'b1;
                    cnt_ld  = 1'b1;
                    cnt_val = START_LOAD;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            ST_START: if (cnt_zero) begin
                sr_n.stream_busy = 1'b0;
                if (!vpp_ok || blk_locked) begin
                    sr_n.ready    = 1'b1;
                    sr_n.pgm_err  = 1'b1;
                    sr_n.vpp_err  = !vpp_ok;
                    sr_n.lock_err = blk_locked;
                    st_n          = ST_IDLE;
                end else begin
                    st_n = ST_PROG;
                end
            end
            ST_PROG, ST_VWAIT: if (host_we) begin
                if (in_blk) begin
                    trk_adv          = 1'b1;
                    sr_n.stream_busy = 1'b1;
                    if (st_q == ST_PROG) begin
                        pls_n   = 1'b1;
                        paddr_n = tgt;
                        pmask_n = ~host_wdata;
                        cnt_ld  = 1'b1;
                        cnt_val = PULSE_LOAD;
                        st_n    = ST_PPULSE;
                    end else begin
                        tgt_n   = tgt;
                        vdata_n = host_wdata;
                        xtra_n  = '0;
                        st_n    = ST_VCHK;
                    end
                end else if (host_wdata == ALL_ONES) begin
                    if (st_q == ST_PROG) begin
                        trk_rew = 1'b1;
                        st_n    = ST_VWAIT;
                    end else begin
                        sr_n.ready = 1'b1;
                        st_n       = ST_IDLE;
                    end
                end else begin
                    sr_n.ready   = 1'b1;
                    sr_n.pgm_err = 1'b1;
                    sr_n.vpp_err = 1'b1;
                    st_n         = ST_IDLE;
                end
            end
            ST_PPULSE: if (cnt_zero) begin
                sr_n.stream_busy = 1'b0;
                st_n             = ST_PROG;
            end
            ST_VCHK: begin
                if (cell_rdata == vdata_q) begin
                    sr_n.stream_busy = 1'b0;
                    st_n             = ST_VWAIT;
                end else if (xtra_q == XTRA_LIM) begin
                    sr_n.pgm_err     = 1'b1;
                    sr_n.stream_busy = 1'b0;
                    st_n             = ST_VWAIT;
                end else begin
                    pls_n   = 1'b1;
                    paddr_n = tgt_q;
                    pmask_n = ~vdata_q;
                    xtra_n  = xtra_q + 1'b1;
                    cnt_ld  = 1'b1;
                    cnt_val = PULSE_LOAD;
                    st_n    = ST_VPULSE;
                end
            end
            ST_VPULSE: if (cnt_zero) st_n = ST_VCHK;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            sr_q    <= STAT_IDLE;
            tgt_q   <= '0;
            vdata_q <= '0;
            xtra_q  <= '0;
            pls_q   <= 1'b0;
            paddr_q <= '0;
            pmask_q <= '0;
        end else begin
            st_q    <= st_n;
            sr_q    <= sr_n;
            tgt_q   <= tgt_n;
            vdata_q <= vdata_n;
            xtra_q  <= xtra_n;
            pls_q   <= pls_n;
            paddr_q <= paddr_n;
            pmask_q <= pmask_n;
        end
    end

    assign status      = pack_status(sr_q);
    assign mode_on     = state_in_mode(st_q);
    assign cell_addr   = (st_q == ST_VCHK) ? tgt_q : host_addr;
    assign host_rdata  = mode_on ? {{(DW-8){1'b0}}, status} : cell_rdata;
    assign pulse_valid = pls_q;
    assign pulse_addr  = paddr_q;
    assign pulse_mask  = pmask_q;
endmodule

// File: rtl/fastprog_ctrl_chk.sv
module fastprog_ctrl_chk #(
    parameter int AW      = 8,
    parameter int BLK_LOW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_on,
    input logic [7:0]    status,
    input logic          pulse_valid,
    input logic [AW-1:0] pulse_addr,
    input logic [AW-1:0] start_addr
);
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !mode_on |-> (status[7] && !status[0])); // R1
    AST_ACTIVE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        mode_on |-> !status[7]); // R1
    AST_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_on) |-> (status == 8'h01)); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_valid |=> !pulse_valid); // R5
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        pulse_valid |-> (mode_on && status[0])); // R4
    AST_PULSE_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        pulse_valid |-> (pulse_addr[AW-1:BLK_LOW] == start_addr[AW-1:BLK_LOW])); // R6
endmodule

bind fastprog_ctrl fastprog_ctrl_chk #(.AW(AW), .BLK_LOW(BLK_LOW)) chk_i (
    .clk(clk), .rst(rst), .mode_on(mode_on), .status(status),
    .pulse_valid(pulse_valid), .pulse_addr(pulse_addr), .start_addr(start_addr)
);

// File: tb/fastprog_ctrl_tb_top.sv
module fastprog_ctrl_tb_top;
    localparam int AW = 6, DW = 16, BLK_LOW = 3;
    localparam int START_CYC = 5, PULSE_CYC = 3, MAX_XTRA = 3;
    localparam int NW = 1 << AW, BW = 1 << BLK_LOW;

    logic clk = 1'b0, rst = 1'b1;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata, cell_rdata, pulse_mask;
    logic vpp_ok = 1'b1, blk_locked = 1'b0;
    logic [AW-1:0] cell_addr, pulse_addr;
    logic pulse_valid, mode_on;
    logic [7:0] status;

    logic [DW-1:0] mem [NW];
    int pcount [NW];
    int pulses;
    logic erase_req = 1'b0;
    logic easy = 1'b0;
    int stubborn = -1;
    int errs = 0, checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fastprog_ctrl #(.AW(AW), .DW(DW), .BLK_LOW(BLK_LOW), .START_CYC(START_CYC),
                    .PULSE_CYC(PULSE_CYC), .MAX_XTRA(MAX_XTRA)) dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .vpp_ok(vpp_ok),
        .blk_locked(blk_locked), .cell_addr(cell_addr), .cell_rdata(cell_rdata),
        .pulse_valid(pulse_valid), .pulse_addr(pulse_addr), .pulse_mask(pulse_mask),
        .status(status), .mode_on(mode_on)
    );

    function automatic int need_of(int w);
        if (w == stubborn) return 100;
        if (easy) return 1;
        return 1 + (w % 3);
    endfunction

    // behavioural cell array: a word clears its bits once it has had enough pulses
    assign cell_rdata = mem[cell_addr];
    always @(posedge clk) begin
        if (erase_req) begin
            for (int i = 0; i < NW; i++) begin
                mem[i]    <= '1;
                pcount[i] <= 0;
            end
            pulses <= 0;
        end else if (pulse_valid) begin
            pcount[pulse_addr] <= pcount[pulse_addr] + 1;
            if (pcount[pulse_addr] + 1 >= need_of(int'(pulse_addr)))
                mem[pulse_addr] <= mem[pulse_addr] & ~pulse_mask;
            pulses <= pulses + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = DW'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic erase();
        @(negedge clk); erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
    endtask

    task automatic enter(input int a);
        int n;
        hwrite(a, 16'h0030);
        hwrite(a, 16'h00D0);
        busy_len(n);
    endtask

    function automatic int pat(int s, int k);
        return (16'h1234 ^ (s * 16'h0911) ^ (k * 16'h0137)) & 16'hFFFF;
    endfunction

    initial begin
        int n, base, oob, w, expp, w2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status == 8'h80 && !mode_on && !pulse_valid, "R1 reset status", status, 8'h80);

        // arm then abort
        hwrite(5, 16'h0030);
        hwrite(5, 16'h00FF);
        hwrite(5, 16'h00D0);
        check(!mode_on && status == 8'h80, "R1 aborted entry", mode_on, 0);

        // startup failures over supply/lock combinations
        for (int c = 1; c < 4; c++) begin
            vpp_ok = !c[0]; blk_locked = c[1];
            hwrite(9, 16'h0030);
            hwrite(9, 16'h00D0);
            check(mode_on && status == 8'h01, "R1 entry status", status, 8'h01);
            busy_len(n);
            check(n == START_CYC, "R1 startup length", n, START_CYC);
            check(!mode_on && status == (8'h90 | (c[0] ? 8'h08 : 8'h00) | (c[1] ? 8'h02 : 8'h00)),
                  "R2 startup error", status, 8'h90 | (c[0] ? 8'h08 : 8'h00) | (c[1] ? 8'h02 : 8'h00));
        end
        vpp_ok = 1'b1; blk_locked = 1'b0;

        // sweep: every start offset, each in its own block, pointer-advance stream
        for (int s = 0; s < BW; s++) begin
            erase();
            base = s * BW;
            oob  = ((s + 1) % (NW / BW)) * BW;
            enter(base + s);
            expp = 0;
            for (int k = 0; k < BW; k++) begin
                hwrite(base + s, pat(s, k));
                busy_len(n);
                if (k == 0) check(n == PULSE_CYC, "R4 pulse busy length", n, PULSE_CYC);
                expp += need_of(base + (s + k) % BW);
            end
            check(pulses == BW, "R5 one pulse per program write", pulses, BW);
            hwrite(oob, 16'hFFFF);
            check(mode_on && status == 8'h00, "R7 verify entered", status, 0);
            for (int k = 0; k < BW; k++) begin
                hwrite(base + s, pat(s, k));
                busy_len(n);
            end
            check(pulses == expp, "R8 verify extra pulses", pulses, expp);
            hwrite(oob, 16'hFFFF);
            check(!mode_on && status == 8'h80, "R10 clean exit", status, 8'h80);
            for (int k = 0; k < BW; k++) begin
                w = base + (s + k) % BW;
                check(mem[w] == DW'(pat(s, k)), "R6 R5 word contents", mem[w], pat(s, k));
            end
        end

        // jumps, wrap, read-status code as data, write during pulse
        erase();
        easy = 1'b1;
        enter(10);
        @(negedge clk); #1;
        check(host_rdata == {8'h00, status}, "R3 read returns status", host_rdata, status);
        hwrite(10, 16'h0070);
        hwrite(12, 16'h0000);
        busy_len(n);
        hwrite(10, 16'hA001);
        busy_len(n);
        hwrite(13, 16'hA002);
        busy_len(n);
        hwrite(10, 16'hA003);
        busy_len(n);
        hwrite(10, 16'hA004);
        busy_len(n);
        hwrite(10, 16'hA005);
        busy_len(n);
        check(pulses == 6, "R4 write during pulse ignored (pulse count)", pulses, 6);
        hwrite(40, 16'hFFFF);
        hwrite(40, 16'hFFFF);
        check(!mode_on && status == 8'h80, "R10 exit", status, 8'h80);
        check(mem[10] == 16'h0070, "R3 status code programmed as data", mem[10], 16'h0070);
        check(mem[11] == 16'hA001, "R6 pointer advance", mem[11], 16'hA001);
        check(mem[12] == 16'hFFFF, "R4 ignored write left word", mem[12], 16'hFFFF);
        check(mem[13] == 16'hA002, "R6 direct jump", mem[13], 16'hA002);
        check(mem[14] == 16'hA003, "R6 pointer after jump", mem[14], 16'hA003);
        check(mem[8] == 16'hA005, "R6 wrap in block", mem[8], 16'hA005);
        host_addr = 10; @(negedge clk); #1;
        check(host_rdata == 16'h0070, "R3 idle read returns array", host_rdata, 16'h0070);
        easy = 1'b0;

        // retry limit reached, verify continues
        erase();
        stubborn = 33;
        enter(33);
        hwrite(33, 16'h0F0F); busy_len(n);
        hwrite(33, 16'h3C3C); busy_len(n);
        hwrite(0, 16'hFFFF);
        hwrite(33, 16'h0F0F); busy_len(n);
        check(status == 8'h10 && mode_on, "R9 limit sets bit 4", status, 8'h10);
        hwrite(33, 16'h3C3C); busy_len(n);
        w2 = need_of(34);
        check(pulses == 2 + MAX_XTRA + w2 - 1, "R9 extra pulse limit", pulses, 2 + MAX_XTRA + w2 - 1);
        check(mem[34] == 16'h3C3C, "R9 next word still verified", mem[34], 16'h3C3C);
        hwrite(0, 16'hFFFF);
        check(!mode_on && status == 8'h90, "R9 R10 exit keeps error", status, 8'h90);
        stubborn = -1;

        // sequence errors in both phases
        erase();
        enter(20);
        hwrite(50, 16'h1234);
        check(!mode_on && status == 8'h98, "R11 program-phase bad terminator", status, 8'h98);
        enter(20);
        check(status == 8'h00, "R1 errors cleared at entry", status, 0);
        hwrite(50, 16'hFFFF);
        hwrite(50, 16'h0000);
        check(!mode_on && status == 8'h98, "R11 verify-phase bad terminator", status, 8'h98);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule